// File: doc/BRIEF.md
# Four-Phase Request/Acknowledge Bus Master

This block is the initiating side of an unclocked request/acknowledge link toward a single target whose response time is unknown and may be very long. A local client hands it one command at a time: direction, address and, for writes, a data word. The block places these on the link and waits a fixed number of its own clock cycles so the target can decode them. Only then does it raise request. It then follows the target's acknowledge line through a full return-to-zero cycle: request high, acknowledge high, request low, acknowledge low.

Acknowledge comes from a different timing domain, so it passes through a chain of flip-flops before the controller looks at it. On a read, the controller samples the target's data bus on the same clock edge where it withdraws request. That is the first edge on which the synchronised acknowledge is seen high. The address, direction and write data stay put until acknowledge has returned low. At that point the block reports completion with a one-cycle pulse and accepts the next command.

If acknowledge never rises, a watchdog counter ends the attempt after a parameterised number of cycles. It drops request, pulses an error flag and returns to idle.

Top module: `hs_master`

## Requirements
- R1: During and after reset, with no command given, `bus_req`, `done` and `err` are low and `cmd_ready` is high.
- R2: A command is accepted on a rising edge where `cmd_ready` and `cmd_valid` are both high. On that edge, `bus_addr`, `bus_write` (1 = write, 0 = read) and `bus_wdata` take the command's values. `bus_req` rises exactly `SETUP_CYC` clock edges later, and `SETUP_CYC` defaults to 2.
- R3: On a write, when the target raises acknowledge, it observes on `bus_addr` and `bus_wdata` the values of the accepted command.
- R4: On a read, `rd_data` holds the value that `bus_rdata` had on the edge where `bus_req` fell. Changes on `bus_rdata` after that edge have no effect on `rd_data`.
- R5: `bus_req` falls only after the synchronised acknowledge has been seen high. With the default two synchroniser stages, `bus_req` falls on the third rising edge after `bus_ack` rises.
- R6: `bus_addr`, `bus_write` and `bus_wdata` stay unchanged from acceptance until the transaction completes or times out, which includes the whole time acknowledge is high.
- R7: If `bus_req` has been high for `TIMEOUT_CYC` cycles (default 256) without acknowledge being seen, `bus_req` falls and `err` pulses for one cycle. `done` does not pulse, and the block returns to idle.
- R8: When acknowledge returns low, `done` pulses for exactly one cycle, on the third rising edge after `bus_ack` falls. It never pulses together with `err`, and `cmd_ready` is high again in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Client offers a command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW | Command address |
| cmd_wdata | input | DW | Write data |
| cmd_ready | output | 1 | High while idle; a command is taken when this and `cmd_valid` are high |
| rd_data | output | DW | Data captured by the last read |
| done | output | 1 | One-cycle pulse when a transaction completes |
| err | output | 1 | One-cycle pulse on acknowledge timeout |
| bus_addr | output | AW | Address driven toward the target |
| bus_write | output | 1 | Direction driven toward the target |
| bus_wdata | output | DW | Write data driven toward the target |
| bus_rdata | input | DW | Read data from the target |
| bus_req | output | 1 | Request line |
| bus_ack | input | 1 | Acknowledge line, asynchronous to `clk` |

## Verification
Several properties are checked on every cycle:

- Request never rises sooner than the decode interval after the address was loaded.
- Request only falls after a synchronised acknowledge or alongside a timeout error.
- The bus fields are held still for as long as a transaction is open.
- `done` and `err` never coincide, `done` follows a low acknowledge, and `err` only follows a high request.

Other facts can only be seen in the bench's scenarios, where a modelled target answers after random delays. These are the exact edge counts through the synchroniser, the read value captured against the target's data being replaced with junk just after request falls, the write values seen by the target, the full 256-cycle timeout, and recovery into a normal transaction afterwards.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETUP   = 2'd1,
        ST_WAIT_HI = 2'd2,
        ST_WAIT_LO = 2'd3
    } hs_state_e;

endpackage

// File: rtl/hs_ack_sync.sv
module hs_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = async_i;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/hs_phase_fsm.sv
module hs_phase_fsm
    import hs_pkg::*;
#(
    parameter int SETUP_CYC   = 2,
    parameter int TIMEOUT_CYC = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic ack_s,
    output logic cmd_ready,
    output logic load_o,
    output logic capture_o,
    output logic busy_o,
    output logic req_o,
    output logic done_o,
    output logic err_o
);
    localparam int CMAX = (TIMEOUT_CYC > SETUP_CYC) ? TIMEOUT_CYC : SETUP_CYC;
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] TMO_LAST   = CW'(TIMEOUT_CYC - 1);

    typedef struct packed {
        hs_state_e     st;
        logic [CW-1:0] cnt;
        logic          req;
        logic          done;
        logic          err;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d      = fsm_q;
        fsm_d.done = 1'b0;
        fsm_d.err  = 1'b0;
        load_o     = 1'b0;
        capture_o  = 1'b0;
        unique case (fsm_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    load_o     = 1'b1;
                    fsm_d.cnt  = '0;
                    fsm_d.st   = ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (fsm_q.cnt == SETUP_LAST) begin
                    fsm_d.cnt = '0;
                    fsm_d.req = 1'b1;
                    fsm_d.st  = ST_WAIT_HI;
                end else begin
                    fsm_d.cnt = fsm_q.cnt + 1'b1;
                end
            end
            ST_WAIT_HI: begin
                if (ack_s) begin
                    capture_o = 1'b1;
                    fsm_d.req = 1'b0;
                    fsm_d.st  = ST_WAIT_LO;
                end else if (fsm_q.cnt == TMO_LAST) begin
                    fsm_d.req = 1'b0;
                    fsm_d.err = 1'b1;
                    fsm_d.st  = ST_IDLE;
                end else begin
                    fsm_d.cnt = fsm_q.cnt + 1'b1;
                end
            end
            ST_WAIT_LO: begin
                if (!ack_s) begin
                    fsm_d.done = 1'b1;
                    fsm_d.st   = ST_IDLE;
                end
            end
            default: fsm_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{st: ST_IDLE, cnt: '0, req: 1'b0, done: 1'b0, err: 1'b0};
        else        fsm_q <= fsm_d;
    end

    assign cmd_ready = (fsm_q.st == ST_IDLE);
    assign busy_o    = (fsm_q.st != ST_IDLE);
    assign req_o     = fsm_q.req;
    assign done_o    = fsm_q.done;
    assign err_o     = fsm_q.err;

    assert_req_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_o) |-> (err_o || $past(ack_s)));
    assert_done_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, err_o}));
    assert_done_after_ack_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(!ack_s) && cmd_ready));
    assert_err_from_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ($past(req_o) && !req_o && cmd_ready));
endmodule

// File: rtl/hs_bus_regs.sv
module hs_bus_regs #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          capture,
    input  logic          cmd_write,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    input  logic [DW-1:0] bus_rdata,
    output logic [AW-1:0] bus_addr,
    output logic          bus_write,
    output logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] rd_data
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic          wr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (load) begin
            regs_d.addr  = cmd_addr;
            regs_d.wr    = cmd_write;
            regs_d.wdata = cmd_write ? cmd_wdata : '0;
        end
        if (capture && !regs_q.wr) begin
            regs_d.rdata = bus_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign bus_addr  = regs_q.addr;
    assign bus_write = regs_q.wr;
    assign bus_wdata = regs_q.wdata;
    assign rd_data   = regs_q.rdata;
endmodule

// File: rtl/hs_master.sv
module hs_master #(
    parameter int AW          = 16,
    parameter int DW          = 32,
    parameter int SETUP_CYC   = 2,
    parameter int TIMEOUT_CYC = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_write,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    output logic          cmd_ready,
    output logic [DW-1:0] rd_data,
    output logic          done,
    output logic          err,
    output logic [AW-1:0] bus_addr,
    output logic          bus_write,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    output logic          bus_req,
    input  logic          bus_ack
);
    localparam int AGE_W = $clog2(SETUP_CYC + 1);

    logic ack_s;
    logic load, capture, busy;

    hs_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (bus_ack),
        .sync_o  (ack_s)
    );

    hs_phase_fsm #(.SETUP_CYC(SETUP_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .ack_s     (ack_s),
        .cmd_ready (cmd_ready),
        .load_o    (load),
        .capture_o (capture),
        .busy_o    (busy),
        .req_o     (bus_req),
        .done_o    (done),
        .err_o     (err)
    );

    hs_bus_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .capture   (capture),
        .cmd_write (cmd_write),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .bus_rdata (bus_rdata),
        .bus_addr  (bus_addr),
        .bus_write (bus_write),
        .bus_wdata (bus_wdata),
        .rd_data   (rd_data)
    );

    // Checker state: cycles since the bus fields were last loaded, saturating.
    logic [AGE_W-1:0] age_d, age_q;
    always_comb begin
        if (load)                                age_d = '0;
        else if (age_q != AGE_W'(SETUP_CYC))     age_d = age_q + 1'b1;
        else                                     age_d = age_q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= AGE_W'(SETUP_CYC);
        else        age_q <= age_d;
    end

    assert_req_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> (age_q == AGE_W'(SETUP_CYC)));
    assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata)));
endmodule

// File: tb/sim_hs_master.sv
module sim_hs_master;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int SETUP = 2;
    localparam int TMO = 256;

    typedef struct {
        bit            wr;
        bit            tmo;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_write = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          cmd_ready;
    logic [DW-1:0] rd_data;
    logic          done, err;
    logic [AW-1:0] bus_addr;
    logic          bus_write;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = 32'hDEAD_BEEF;
    logic          bus_req;
    logic          bus_ack = 1'b0;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  mute    = 1'b0;
    bit  finished = 1'b0;
    item_t exp_q[$];
    item_t obs_q[$];

    always #10 clk = ~clk;

    hs_master #(.AW(AW), .DW(DW), .SETUP_CYC(SETUP), .TIMEOUT_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
        .rd_data(rd_data), .done(done), .err(err), .bus_addr(bus_addr),
        .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_req(bus_req), .bus_ack(bus_ack)
    );

    function automatic logic [DW-1:0] rd_fn(logic [AW-1:0] a);
        return {a, ~a} ^ 32'h5A5A_0F0F;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Target model: random response delays, junk on the data bus outside the ack window.
    initial begin
        forever begin
            @(negedge clk);
            if (bus_req && !mute && !bus_ack) begin
                logic [AW-1:0] a0;
                int k;
                item_t o;
                repeat ($urandom % 6) @(negedge clk);
                a0 = bus_addr;
                o.wr = bus_write; o.tmo = 1'b0; o.addr = bus_addr; o.data = bus_wdata;
                obs_q.push_back(o);
                bus_rdata = rd_fn(bus_addr);
                bus_ack = 1'b1;
                k = 0;
                do begin @(negedge clk); k++; end while (bus_req && k < 20);
                chk(k == 3, "R5", "edges from ack rise to req fall", 64'(k), 64'd3);
                bus_rdata = 32'hDEAD_BEEF;
                repeat ($urandom % 5) @(negedge clk);
                chk(bus_addr == a0, "R6", "address held while ack high", 64'(bus_addr), 64'(a0));
                bus_ack = 1'b0;
            end
        end
    end

    // Monitor: pops the expected item on each completion or error.
    always @(negedge clk) begin
        if (rst_n && (done || err)) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8", "unexpected completion pulse", 64'({done, err}), 64'd0);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                chk(!(done && err), "R8", "done and err together", 64'({done, err}), 64'd2);
                if (e.tmo) begin
                    chk(err && !done, "R7", "timeout reports err only", 64'({done, err}), 64'd1);
                end else begin
                    chk(done && !err, "R8", "completion reports done", 64'({done, err}), 64'd2);
                    if (obs_q.size() != 0) begin
                        item_t o;
                        o = obs_q.pop_front();
                        chk(o.addr == e.addr && o.wr == e.wr, "R3", "target saw addr/dir",
                            64'({o.wr, o.addr}), 64'({e.wr, e.addr}));
                        if (e.wr)
                            chk(o.data == e.data, "R3", "target saw write data", 64'(o.data), 64'(e.data));
                        else
                            chk(rd_data == e.data, "R4", "read data captured", 64'(rd_data), 64'(e.data));
                    end else begin
                        chk(1'b0, "R3", "target saw no transaction", 64'd0, 64'd1);
                    end
                    chk(cmd_ready, "R8", "ready with done", 64'(cmd_ready), 64'd1);
                end
            end
        end
    end

    task automatic do_cmd(bit wr, logic [AW-1:0] a, logic [DW-1:0] d, bit tmo);
        item_t e;
        int lo;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        e.wr = wr; e.tmo = tmo; e.addr = a; e.data = wr ? d : rd_fn(a);
        exp_q.push_back(e);
        cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_addr = ~a; cmd_wdata = ~d; cmd_write = ~wr;
        chk(bus_addr == a && bus_write == wr, "R2", "bus fields after accept",
            64'({bus_write, bus_addr}), 64'({wr, a}));
        lo = 1;
        while (!bus_req && lo < 50) begin @(negedge clk); if (!bus_req) lo++; end
        chk(lo == SETUP, "R2", "cycles before request", 64'(lo), 64'(SETUP));
        if (wr) chk(bus_wdata == d, "R2", "write data on bus", 64'(bus_wdata), 64'(d));
        if (tmo) begin
            int hi;
            hi = 1;
            while (bus_req && hi < 400) begin @(negedge clk); if (bus_req) hi++; end
            chk(hi == TMO, "R7", "request high cycles before timeout", 64'(hi), 64'(TMO));
        end
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        chk(!bus_req, "R7", "request low when idle", 64'(bus_req), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!bus_req, "R1", "req in reset", 64'(bus_req), 64'd0);
        chk(cmd_ready, "R1", "ready in reset", 64'(cmd_ready), 64'd1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!done && !err, "R1", "no pulses after reset", 64'({done, err}), 64'd0);
        chk(!bus_req && cmd_ready, "R1", "idle after reset", 64'({bus_req, cmd_ready}), 64'd1);

        do_cmd(1'b1, 16'h1234, 32'hCAFE_0001, 1'b0);
        do_cmd(1'b0, 16'h1234, '0, 1'b0);
        do_cmd(1'b0, 16'hFFFF, '0, 1'b0);
        do_cmd(1'b1, 16'h0000, 32'hFFFF_FFFF, 1'b0);
        for (int i = 0; i < 12; i++)
            do_cmd(i[0], 16'($urandom), $urandom, 1'b0);

        mute = 1'b1;
        do_cmd(1'b0, 16'hBEEF, '0, 1'b1);
        mute = 1'b0;
        do_cmd(1'b0, 16'h0A0A, '0, 1'b0);
        do_cmd(1'b1, 16'h5555, 32'h1357_9BDF, 1'b0);
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R8", "all transactions completed", 64'(exp_q.size()), 64'd0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule